// File: doc/BRIEF.md
# Operand-Registered 8-bit ALU Datapath

This block is the arithmetic and logic datapath of a small 8-bit processor. It has two operand registers, A-side and B-side, that are loaded under strobes from the accumulator, an address byte, a data byte or its own result. A combinational core applies one of five operations, chosen by one-hot selects from an external control decoder. A hold register captures the result and the three flags under a load strobe. The decoder, status register and buses are outside the block. They appear here only as source bytes, a status carry input and control strobes.

No opcode exists for subtraction, left shift or increment. The sequencer gets each of them from the way it loads the operands and the carry. Subtraction loads the B side with a complemented byte and adds with carry. Left shift loads the same byte on both sides. Increment clears the A side and forces the carry to 1. Because the A side can reload from the hold register, multi-byte address arithmetic can be chained. A decimal-mode input turns the add into a packed-BCD add with per-nibble correction.

An operation takes two clock cycles. On the first edge the operands are loaded. On the second edge, with a select active and `hold_ld` high, the result is captured. The registered outputs are valid after that second edge.

Top module: `alu8_datapath`

## Requirements
- R1: At most one of `sel_sum`, `sel_and`, `sel_xor`, `sel_or`, `sel_shr` is high in any cycle. With none high, a capture stores a zero result and clears carry, overflow and half carry.
- R2: In binary mode the add stores the low 8 bits of A + B + carry-in and sets `carry_out` to bit 8 of that sum. Loading the same byte on both sides gives a left shift, and the shifted-out bit appears as carry.
- R3: After an add, `overflow` is 1 exactly when A and B have equal bit 7 and the bit-7 sum (before any decimal correction of the high nibble) differs from it.
- R4: In binary mode `half_carry` is the carry out of bit 3 of the add.
- R5: The carry-in source is set by `cin_sel`: 00 gives 0, 01 gives `c_flag`, 10 gives 1, and 11 gives 0.
- R6: When `bi_ld` is high the B register loads `dat_in`, or `acc_in` if `bi_from_acc` is high. The byte is complemented first when `bi_inv` is high. Adding the complement gives A − B − 1 + carry-in.
- R7: When `ai_ld` is high the A register loads the source set by `ai_src`: 00 gives `acc_in`, 01 gives `adr_in`, 10 gives the held result, and 11 gives zero. Neither operand register changes while its load strobe is low.
- R8: AND, XOR and OR store the bitwise result of A and B, and clear all three flags.
- R9: Shift right stores A moved one place toward bit 0, with carry-in entering bit 7. It sets `carry_out` to the old bit 0 and clears overflow and half carry.
- R10: With `dec_mode` high, the add adds 6 to each nibble whose binary sum with its incoming carry exceeds 9. That nibble then passes a carry on. `half_carry` is the low nibble's correction and `carry_out` is the high nibble's correction.
- R11: The result and flag outputs change only on a clock edge where `hold_ld` is high.
- R12: While reset is applied, and after it, the operand registers, the result and all flags read zero until the first capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with the clock |
| acc_in | input | 8 | Accumulator byte, an A or B source |
| adr_in | input | 8 | Address byte, an A source |
| dat_in | input | 8 | Data byte, a B source |
| c_flag | input | 1 | Status carry bit, a carry-in source |
| ai_ld | input | 1 | Load strobe for the A register |
| ai_src | input | 2 | A source select |
| bi_ld | input | 1 | Load strobe for the B register |
| bi_inv | input | 1 | Complement the byte loaded into B |
| bi_from_acc | input | 1 | Take B from `acc_in` instead of `dat_in` |
| sel_sum | input | 1 | Select add |
| sel_and | input | 1 | Select AND |
| sel_xor | input | 1 | Select exclusive OR |
| sel_or | input | 1 | Select OR |
| sel_shr | input | 1 | Select shift right |
| cin_sel | input | 2 | Carry-in source select |
| dec_mode | input | 1 | Decimal add mode |
| hold_ld | input | 1 | Capture strobe for the hold register |
| result | output | 8 | Held result |
| carry_out | output | 1 | Held carry |
| overflow | output | 1 | Held signed overflow |
| half_carry | output | 1 | Held half carry |

## Verification
The add is tried with the following operand pairs:
- Pairs with no carries at all.
- Pairs that ripple a carry through both nibbles.
- Pairs with equal signs that overflow in each direction.
- The same byte on both sides.

Together these separate the carry, half-carry and overflow terms from one another. Each of the four carry-in codes is applied to the same 0x0F + 0x00 pair, so only the carry source decides whether the result is 0x0F or 0x10.

Decimal adds are chosen in these groups:
- Only the low nibble needs correction.
- Both nibbles need correction.
- Only the high nibble needs correction.
- Neither nibble needs correction.

This shows that each nibble's fix-up, and the carry it produces, is independent.

The directed sequences check the rest:
- Subtraction with and without borrow.
- Increment from a cleared A side.
- Feedback from the hold register.
- Loads with a strobe low.
- Captures with `hold_ld` low or with no select.

These confirm that operand state and held state move only when their strobes say so.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  // Source feeding the A-side operand register
  typedef enum logic [1:0] {
    AI_ACC  = 2'b00,
    AI_ADR  = 2'b01,
    AI_HOLD = 2'b10,
    AI_ZERO = 2'b11
  } ai_src_e;

  // Carry-in source into the core
  typedef enum logic [1:0] {
    CI_ZERO  = 2'b00,
    CI_FLAG  = 2'b01,
    CI_ONE   = 2'b10,
    CI_ZERO2 = 2'b11
  } cin_sel_e;

  // One-hot operation selects from the control decoder
  typedef struct packed {
    logic sum;
    logic andl;
    logic xorl;
    logic orl;
    logic shr;
  } op_sel_t;

  typedef struct packed {
    logic c;
    logic v;
    logic h;
  } alu_flags_t;

  localparam int unsigned NIB_W     = 4;
  localparam int unsigned BCD_LIMIT = 9;
  localparam int unsigned BCD_FIX   = 6;

endpackage

// File: rtl/alu8_operands.sv
module alu8_operands
  import alu8_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ai_ld,
  input  logic [1:0]   ai_src,
  input  logic [W-1:0] acc_in,
  input  logic [W-1:0] adr_in,
  input  logic [W-1:0] hold_in,
  input  logic         bi_ld,
  input  logic         bi_inv,
  input  logic         bi_from_acc,
  input  logic [W-1:0] dat_in,
  output logic [W-1:0] ai_q,
  output logic [W-1:0] bi_q
);

  logic [W-1:0] ai_d;
  logic [W-1:0] bi_d;
  logic [W-1:0] bi_base;

  // Next-state for the A side
  always_comb begin
    ai_d = ai_q;
    if (ai_ld) begin
      unique case (ai_src_e'(ai_src))
        AI_ACC:  ai_d = acc_in;
        AI_ADR:  ai_d = adr_in;
        AI_HOLD: ai_d = hold_in;
        AI_ZERO: ai_d = '0;
        default: ai_d = '0;
      endcase
    end
  end

  // Next-state for the B side: byte or its complement
  always_comb begin
    bi_base = bi_from_acc ? acc_in : dat_in;
    bi_d    = bi_q;
    if (bi_ld) begin
      bi_d = bi_inv ? ~bi_base : bi_base;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ai_q <= '0;
      bi_q <= '0;
    end else begin
      ai_q <= ai_d;
      bi_q <= bi_d;
    end
  end

  assert_ai_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ai_ld |=> $stable(ai_q));

  assert_bi_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !bi_ld |=> $stable(bi_q));

  assert_ai_feedback_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ai_ld && ai_src == 2'b10) |=> ai_q == $past(hold_in));

  assert_bi_invert_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bi_ld && bi_inv && !bi_from_acc) |=> bi_q == ~$past(dat_in));

endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] ai,
  input  logic [W-1:0] bi,
  input  op_sel_t      op,
  input  logic [1:0]   cin_sel,
  input  logic         c_flag,
  input  logic         dec_mode,
  output logic [W-1:0] res,
  output alu_flags_t   flg
);

  localparam int unsigned NN = W / NIB_W;

  logic          cin;
  logic [NN:0]   nib_c;       // carry into each nibble
  logic [NN-1:0] nib_msb;     // bit 3 of each uncorrected nibble sum
  logic [W-1:0]  sum_res;
  logic          sum_ovf;

  // Carry-in multiplexer
  always_comb begin
    unique case (cin_sel_e'(cin_sel))
      CI_ZERO:  cin = 1'b0;
      CI_FLAG:  cin = c_flag;
      CI_ONE:   cin = 1'b1;
      CI_ZERO2: cin = 1'b0;
      default:  cin = 1'b0;
    endcase
  end

  assign nib_c[0] = cin;

  // Nibble-sliced adder; each slice optionally applies decimal correction
  for (genvar k = 0; k < NN; k++) begin : g_nib
    logic [NIB_W:0]   raw;
    logic             fix;
    assign raw = {1'b0, ai[k*NIB_W +: NIB_W]}
               + {1'b0, bi[k*NIB_W +: NIB_W]}
               + {{NIB_W{1'b0}}, nib_c[k]};
    assign fix = dec_mode && (raw > (NIB_W+1)'(BCD_LIMIT));
    assign nib_c[k+1] = dec_mode ? fix : raw[NIB_W];
    assign nib_msb[k] = raw[NIB_W-1];
    assign sum_res[k*NIB_W +: NIB_W] = raw[NIB_W-1:0]
                                     + (fix ? NIB_W'(BCD_FIX) : '0);
  end

  assign sum_ovf = (ai[W-1] == bi[W-1]) && (nib_msb[NN-1] != ai[W-1]);

  // Operation selection
  always_comb begin
    res = '0;
    flg = '0;
    if (op.sum) begin
      res   = sum_res;
      flg.c = nib_c[NN];
      flg.v = sum_ovf;
      flg.h = nib_c[1];
    end else if (op.andl) begin
      res = ai & bi;
    end else if (op.xorl) begin
      res = ai ^ bi;
    end else if (op.orl) begin
      res = ai | bi;
    end else if (op.shr) begin
      res   = {cin, ai[W-1:1]};
      flg.c = ai[0];
    end
  end

endmodule

// File: rtl/alu8_hold.sv
module alu8_hold
  import alu8_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] res_d,
  input  alu_flags_t   flg_d,
  output logic [W-1:0] res_q,
  output alu_flags_t   flg_q
);

  logic [W-1:0] res_n;
  alu_flags_t   flg_n;

  always_comb begin
    res_n = res_q;
    flg_n = flg_q;
    if (ld) begin
      res_n = res_d;
      flg_n = flg_d;
    end
  end

  // R12: cleared while reset is applied
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      flg_q <= '0;
    end else begin
      res_q <= res_n;
      flg_q <= flg_n;
    end
  end

  assert_hold_keep_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> ($stable(res_q) && $stable(flg_q)));

  assert_hold_take_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (res_q == $past(res_d) && flg_q == $past(flg_d)));

endmodule

// File: rtl/alu8_datapath.sv
module alu8_datapath
  import alu8_pkg::*;
#(
  parameter int unsigned W = 8   // must be a multiple of 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] acc_in,
  input  logic [W-1:0] adr_in,
  input  logic [W-1:0] dat_in,
  input  logic         c_flag,
  input  logic         ai_ld,
  input  logic [1:0]   ai_src,
  input  logic         bi_ld,
  input  logic         bi_inv,
  input  logic         bi_from_acc,
  input  logic         sel_sum,
  input  logic         sel_and,
  input  logic         sel_xor,
  input  logic         sel_or,
  input  logic         sel_shr,
  input  logic [1:0]   cin_sel,
  input  logic         dec_mode,
  input  logic         hold_ld,
  output logic [W-1:0] result,
  output logic         carry_out,
  output logic         overflow,
  output logic         half_carry
);

  logic [1:0]   rst_sync;
  logic         rst_int_n;
  logic [W-1:0] ai_q;
  logic [W-1:0] bi_q;
  logic [W-1:0] core_res;
  alu_flags_t   core_flg;
  alu_flags_t   held_flg;
  op_sel_t      op;

  // Asynchronous assert, clocked release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  assign op = '{sum: sel_sum, andl: sel_and, xorl: sel_xor, orl: sel_or, shr: sel_shr};

  alu8_operands #(.W(W)) u_operands (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .ai_ld       (ai_ld),
    .ai_src      (ai_src),
    .acc_in      (acc_in),
    .adr_in      (adr_in),
    .hold_in     (result),
    .bi_ld       (bi_ld),
    .bi_inv      (bi_inv),
    .bi_from_acc (bi_from_acc),
    .dat_in      (dat_in),
    .ai_q        (ai_q),
    .bi_q        (bi_q)
  );

  alu8_core #(.W(W)) u_core (
    .ai       (ai_q),
    .bi       (bi_q),
    .op       (op),
    .cin_sel  (cin_sel),
    .c_flag   (c_flag),
    .dec_mode (dec_mode),
    .res      (core_res),
    .flg      (core_flg)
  );

  alu8_hold #(.W(W)) u_hold (
    .clk   (clk),
    .rst_n (rst_int_n),
    .ld    (hold_ld),
    .res_d (core_res),
    .flg_d (core_flg),
    .res_q (result),
    .flg_q (held_flg)
  );

  assign carry_out  = held_flg.c;
  assign overflow   = held_flg.v;
  assign half_carry = held_flg.h;

  assert_sel_onehot_R1: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0({sel_sum, sel_and, sel_xor, sel_or, sel_shr}));

  assert_noop_zero_R1: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(sel_sum || sel_and || sel_xor || sel_or || sel_shr) |-> (core_res == '0 && core_flg == '0));

  assert_bin_add_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (sel_sum && !dec_mode && cin_sel == 2'b00)
      |-> {core_flg.c, core_res} == ({1'b0, ai_q} + {1'b0, bi_q}));

  assert_forced_cin_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (sel_sum && !dec_mode && cin_sel == 2'b10)
      |-> {core_flg.c, core_res} == ({1'b0, ai_q} + {1'b0, bi_q} + (W+1)'(1)));

  assert_logic_flags_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (sel_and || sel_xor || sel_or) |-> core_flg == '0);

  assert_shift_carry_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    sel_shr |-> (core_flg.c == ai_q[0] && !core_flg.v && !core_flg.h));

endmodule

// File: tb/test_alu8_datapath.sv
`timescale 1ns/1ps
module test_alu8_datapath;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] acc_in, adr_in, dat_in;
  logic       c_flag, ai_ld, bi_ld, bi_inv, bi_from_acc;
  logic [1:0] ai_src, cin_sel;
  logic       sel_sum, sel_and, sel_xor, sel_or, sel_shr, dec_mode, hold_ld;
  logic [7:0] result;
  logic       carry_out, overflow, half_carry;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  alu8_datapath i_alu8_datapath (
    .clk(clk), .rst_n(rst_n), .acc_in(acc_in), .adr_in(adr_in), .dat_in(dat_in),
    .c_flag(c_flag), .ai_ld(ai_ld), .ai_src(ai_src), .bi_ld(bi_ld), .bi_inv(bi_inv),
    .bi_from_acc(bi_from_acc), .sel_sum(sel_sum), .sel_and(sel_and), .sel_xor(sel_xor),
    .sel_or(sel_or), .sel_shr(sel_shr), .cin_sel(cin_sel), .dec_mode(dec_mode),
    .hold_ld(hold_ld), .result(result), .carry_out(carry_out), .overflow(overflow),
    .half_carry(half_carry)
  );

  // {tag[3:0], op{sum,and,xor,or,shr}[4:0], a, b, cin_sel, c_flag, dec, exp_res, c, v, h}
  localparam int NV = 18;
  localparam logic [39:0] VEC [NV] = '{
    {4'd2,  5'b10000, 8'h12, 8'h34, 2'd0, 1'b0, 1'b0, 8'h46, 1'b0, 1'b0, 1'b0}, // R2 plain add
    {4'd4,  5'b10000, 8'hFF, 8'h01, 2'd0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1}, // R4 ripple
    {4'd3,  5'b10000, 8'h50, 8'h50, 2'd0, 1'b0, 1'b0, 8'hA0, 1'b0, 1'b1, 1'b0}, // R3 pos ovf
    {4'd3,  5'b10000, 8'h80, 8'h80, 2'd0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0}, // R3 neg ovf
    {4'd5,  5'b10000, 8'h0F, 8'h00, 2'd1, 1'b1, 1'b0, 8'h10, 1'b0, 1'b0, 1'b1}, // R5 flag=1
    {4'd5,  5'b10000, 8'h0F, 8'h00, 2'd1, 1'b0, 1'b0, 8'h0F, 1'b0, 1'b0, 1'b0}, // R5 flag=0
    {4'd5,  5'b10000, 8'h0F, 8'h00, 2'd2, 1'b0, 1'b0, 8'h10, 1'b0, 1'b0, 1'b1}, // R5 forced 1
    {4'd5,  5'b10000, 8'h0F, 8'h00, 2'd3, 1'b1, 1'b0, 8'h0F, 1'b0, 1'b0, 1'b0}, // R5 code 11
    {4'd8,  5'b01000, 8'hF0, 8'h3C, 2'd2, 1'b0, 1'b0, 8'h30, 1'b0, 1'b0, 1'b0}, // R8 AND
    {4'd8,  5'b00100, 8'hF0, 8'h3C, 2'd2, 1'b0, 1'b0, 8'hCC, 1'b0, 1'b0, 1'b0}, // R8 XOR
    {4'd8,  5'b00010, 8'hF0, 8'h3C, 2'd2, 1'b0, 1'b0, 8'hFC, 1'b0, 1'b0, 1'b0}, // R8 OR
    {4'd9,  5'b00001, 8'h81, 8'h00, 2'd0, 1'b0, 1'b0, 8'h40, 1'b1, 1'b0, 1'b0}, // R9 cin 0
    {4'd9,  5'b00001, 8'h02, 8'h00, 2'd2, 1'b0, 1'b0, 8'h81, 1'b0, 1'b0, 1'b0}, // R9 cin 1
    {4'd10, 5'b10000, 8'h45, 8'h38, 2'd0, 1'b0, 1'b1, 8'h83, 1'b0, 1'b1, 1'b1}, // R10 low fix
    {4'd10, 5'b10000, 8'h99, 8'h01, 2'd0, 1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 1'b1}, // R10 both
    {4'd10, 5'b10000, 8'h50, 8'h50, 2'd0, 1'b0, 1'b1, 8'h00, 1'b1, 1'b1, 1'b0}, // R10 high fix
    {4'd10, 5'b10000, 8'h12, 8'h34, 2'd2, 1'b0, 1'b1, 8'h47, 1'b0, 1'b0, 1'b0}, // R10 no fix
    {4'd2,  5'b10000, 8'hC1, 8'hC1, 2'd0, 1'b0, 1'b0, 8'h82, 1'b1, 1'b0, 1'b0}  // R2 left shift
  };

  task automatic check(input string tag, input logic [7:0] er, input logic ec, ev, eh);
    checks++;
    if (result !== er || carry_out !== ec || overflow !== ev || half_carry !== eh) begin
      errors++;
      $display("FAIL %s: got res=%h c=%b v=%b h=%b, expected res=%h c=%b v=%b h=%b",
               tag, result, carry_out, overflow, half_carry, er, ec, ev, eh);
    end
  endtask

  task automatic load_ops(input logic do_ai, input logic [1:0] src, input logic [7:0] acc,
                          input logic [7:0] adr, input logic do_bi, input logic [7:0] dat,
                          input logic inv, input logic from_acc);
    @(negedge clk);
    ai_ld = do_ai; ai_src = src; acc_in = acc; adr_in = adr;
    bi_ld = do_bi; dat_in = dat; bi_inv = inv; bi_from_acc = from_acc;
    @(negedge clk);
    ai_ld = 1'b0; bi_ld = 1'b0;
  endtask

  // Sets selects at the current negedge; captured at next posedge; sampled at next negedge
  task automatic run_op(input logic [4:0] op, input logic [1:0] cs, input logic cf,
                        input logic dec, input logic hl);
    {sel_sum, sel_and, sel_xor, sel_or, sel_shr} = op;
    cin_sel = cs; c_flag = cf; dec_mode = dec; hold_ld = hl;
    @(negedge clk);
    {sel_sum, sel_and, sel_xor, sel_or, sel_shr} = 5'b0;
    hold_ld = 1'b0; dec_mode = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    acc_in = '0; adr_in = '0; dat_in = '0; c_flag = 1'b0;
    ai_ld = 1'b0; ai_src = 2'b00; bi_ld = 1'b0; bi_inv = 1'b0; bi_from_acc = 1'b0;
    sel_sum = 1'b0; sel_and = 1'b0; sel_xor = 1'b0; sel_or = 1'b0; sel_shr = 1'b0;
    cin_sel = 2'b00; dec_mode = 1'b0; hold_ld = 1'b0;
    repeat (3) @(negedge clk);
    check("R12 during reset", 8'h00, 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R12 after reset", 8'h00, 1'b0, 1'b0, 1'b0);
    // R12: operands read zero: capture A+B with no loads
    run_op(5'b10000, 2'd0, 1'b0, 1'b0, 1'b1);
    check("R12 operands zero", 8'h00, 1'b0, 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      load_ops(1'b1, 2'b00, VEC[i][30:23], 8'h00, 1'b1, VEC[i][22:15], 1'b0, 1'b0);
      run_op(VEC[i][35:31], VEC[i][14:13], VEC[i][12], VEC[i][11], 1'b1);
      check($sformatf("R%0d vector %0d", VEC[i][39:36], i),
            VEC[i][10:3], VEC[i][2], VEC[i][1], VEC[i][0]);
    end

    // R6 subtract without borrow: 0x50 - 0x20 via complement, carry 1
    load_ops(1'b1, 2'b00, 8'h50, 8'h00, 1'b1, 8'h20, 1'b1, 1'b0);
    run_op(5'b10000, 2'd2, 1'b0, 1'b0, 1'b1);
    check("R6 subtract no borrow", 8'h30, 1'b1, 1'b0, 1'b1);
    run_op(5'b10000, 2'd0, 1'b0, 1'b0, 1'b1);
    check("R6 subtract with borrow", 8'h2F, 1'b1, 1'b0, 1'b0);

    // R6 B from accumulator: left shift of 0xC1
    load_ops(1'b1, 2'b00, 8'hC1, 8'h00, 1'b1, 8'h00, 1'b0, 1'b1);
    run_op(5'b10000, 2'd0, 1'b0, 1'b0, 1'b1);
    check("R6 B from acc shift", 8'h82, 1'b1, 1'b0, 1'b0);

    // R7 increment: A cleared, forced carry
    load_ops(1'b1, 2'b11, 8'h77, 8'h00, 1'b1, 8'hFF, 1'b0, 1'b0);
    run_op(5'b10000, 2'd2, 1'b0, 1'b0, 1'b1);
    check("R7 increment from zero A", 8'h00, 1'b1, 1'b0, 1'b1);

    // R7 hold feedback chain
    load_ops(1'b1, 2'b00, 8'h10, 8'h00, 1'b1, 8'h20, 1'b0, 1'b0);
    run_op(5'b10000, 2'd0, 1'b0, 1'b0, 1'b1);
    check("R7 chain first", 8'h30, 1'b0, 1'b0, 1'b0);
    load_ops(1'b1, 2'b10, 8'hEE, 8'h00, 1'b1, 8'h05, 1'b0, 1'b0);
    run_op(5'b10000, 2'd0, 1'b0, 1'b0, 1'b1);
    check("R7 chain from hold", 8'h35, 1'b0, 1'b0, 1'b0);

    // R7 address source, then A kept while its strobe is low
    load_ops(1'b1, 2'b01, 8'hEE, 8'h07, 1'b1, 8'h01, 1'b0, 1'b0);
    run_op(5'b10000, 2'd0, 1'b0, 1'b0, 1'b1);
    check("R7 address source", 8'h08, 1'b0, 1'b0, 1'b0);
    load_ops(1'b0, 2'b00, 8'hAA, 8'h00, 1'b1, 8'h02, 1'b0, 1'b0);
    run_op(5'b10000, 2'd0, 1'b0, 1'b0, 1'b1);
    check("R7 A unchanged without strobe", 8'h09, 1'b0, 1'b0, 1'b0);

    // R11 no capture without hold_ld
    load_ops(1'b1, 2'b00, 8'h01, 8'h00, 1'b1, 8'h01, 1'b0, 1'b0);
    run_op(5'b10000, 2'd0, 1'b0, 1'b0, 1'b0);
    check("R11 held without strobe", 8'h09, 1'b0, 1'b0, 1'b0);
    run_op(5'b10000, 2'd0, 1'b0, 1'b0, 1'b1);
    check("R11 captured with strobe", 8'h02, 1'b0, 1'b0, 1'b0);

    // R1 no select clears result and flags
    load_ops(1'b1, 2'b00, 8'hFF, 8'h00, 1'b1, 8'h01, 1'b0, 1'b0);
    run_op(5'b10000, 2'd0, 1'b0, 1'b0, 1'b1);
    check("R1 setup flags", 8'h00, 1'b1, 1'b0, 1'b1);
    run_op(5'b00000, 2'd2, 1'b1, 1'b0, 1'b1);
    check("R1 no select", 8'h00, 1'b0, 1'b0, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule